// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block is a slave-mode input port for serial stereo audio. An external source drives a bit clock, a channel-select line and a serial data line. The block turns them into parallel left and right 16-bit words with a one-cycle valid strobe, ready for a stereo DAC path. All three serial inputs are asynchronous to the system clock. They are resynchronised and oversampled, and every event is taken on a rising edge of the bit clock.

Two framings are supported, and a 2-bit format field picks one of them. The standard I2S framing uses the channel-select line to mark words. The two-wire framing ignores that line and cuts the data stream into fixed groups of 32 bits. The port does nothing unless two independent enable bits are both high. In I2S mode the block checks that each channel-select period holds at least 32 bit clocks. A frame that is too short sets a sticky error flag, and dropping either enable clears that flag.

Timing rule for the user: each high phase and each low phase of the bit clock must last at least three system clock cycles. A 250 MHz system clock therefore supports bit clocks well above 6.4 MHz and sample rates above 50 kHz.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_o`, `right_o`, `valid_o` and `frame_err_o` are all zero.
- R2: While `card_en_i` and `path_en_i` are not both 1, the port stays idle. No valid strobe appears, `left_o` and `right_o` read zero, and serial activity has no effect.
- R3: I2S framing is selected by `fmt_i` values 2'b00, 2'b10 and 2'b11. The channel-select level and the data are sampled on rising bit-clock edges. The MSB of a word arrives one bit clock after a channel-select transition, and bits follow MSB first. A low channel-select marks the left word and a high one marks the right word.
- R4: In I2S mode, only the first 16 bits of each word are kept. Any count of 32 or more bit clocks per channel-select period is accepted without an error.
- R5: After the port is enabled, a word is reported only if its channel-select transition was seen while the port was enabled. The first frame after enabling, which may be partial, is therefore never reported.
- R6: In I2S mode, if fewer than 32 bit clocks fall between two successive high-to-low channel-select transitions, `frame_err_o` rises. It stays high while the port remains enabled.
- R7: Clearing either enable drops `frame_err_o` to 0 within one clock.
- R8: `fmt_i` = 2'b01 selects two-wire framing. Starting from the first bit after enabling, each group of 32 bits forms one frame: the left word first, then the right word, each MSB first.
- R9: In two-wire mode the channel-select input has no effect. Toggling it changes neither the captured data nor `frame_err_o`.
- R10: `valid_o` is high for exactly one clock for each completed frame. `left_o` and `right_o` hold that frame's words until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_en_i | input | 1 | Card-level enable |
| path_en_i | input | 1 | Data-path enable |
| fmt_i | input | 2 | Framing select: 2'b01 selects two-wire, any other value selects I2S |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrsel_i | input | 1 | Channel select: 0 = left, 1 = right (I2S mode only) |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 16 | Left word of the last completed frame |
| right_o | output | 16 | Right word of the last completed frame |
| valid_o | output | 1 | One-clock strobe when a frame completes |
| frame_err_o | output | 1 | Sticky short-frame flag |

## Verification
If the bit position or the channel tracking is wrong, `left_o` and `right_o` show rotated or swapped words on the first reported frame. That happens one output register after the rising bit-clock edge that ends the right word. If the synchronisation state is wrong, the number of valid strobes for a known stream comes out wrong: either the partial first frame gets reported or a real frame goes missing. A wrong frame-length count shows up on `frame_err_o` at the second high-to-low channel-select transition after enabling. If the count is too eager, the flag rises on legal long frames. If it is too lax, the flag stays low on 30-clock frames.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam logic [1:0] FMT_TWO_WIRE = 2'b01;

  // Two-wire framing has exactly one code; all others select I2S.
  function automatic logic fmt_is_two_wire(input logic [1:0] fmt);
    return fmt == FMT_TWO_WIRE;
  endfunction

  // A channel-select period is short when it held fewer bit clocks than the minimum.
  function automatic logic period_too_short(input int unsigned ticks,
                                            input int unsigned min_ticks);
    return ticks < min_ticks;
  endfunction

  // Bit index (MSB first) of serial position pos inside a word of width w.
  function automatic int unsigned msb_first_index(input int unsigned pos,
                                                  input int unsigned w);
    return w - 1 - pos;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrsel_i,
  input  logic sdata_i,
  output logic tick_o,
  output logic lrsel_o,
  output logic sdata_o
);
  localparam int LANES = 3;
  localparam int TOP   = STAGES * LANES;

  logic [TOP-1:0] chain_q;
  logic           bclk_prev_q;
  logic           bclk_s;

  // Every lane moves through the same number of stages, so each sampled
  // value is aligned with the bit-clock level it goes with.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q     <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      chain_q     <= {chain_q[TOP-LANES-1:0], bclk_i, lrsel_i, sdata_i};
      bclk_prev_q <= bclk_s;
    end
  end

  assign bclk_s  = chain_q[TOP-1];
  assign lrsel_o = chain_q[TOP-2];
  assign sdata_o = chain_q[TOP-3];
  assign tick_o  = bclk_s & ~bclk_prev_q;

  // R3: one rising bit-clock edge yields exactly one sampling tick
  a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/sar_i2s_framer.sv
module sar_i2s_framer #(
  parameter int WORD_W   = 16,
  parameter int MIN_BCLK = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              lrsel_i,
  input  logic              sdata_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              short_o
);
  import sar_pkg::*;

  localparam int IDX_W = $clog2(WORD_W + 1);
  localparam int CNT_W = $clog2(MIN_BCLK + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_BCLK);

  logic              lr_prev_q;
  logic              synced_q;
  logic              left_seen_q;
  logic              armed_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] lhold_q;

  // Named events for assertions and readability
  logic              lr_edge;
  logic              lr_fall;
  logic              bit_take;
  logic [WORD_W-1:0] word_next;

  assign lr_edge   = tick_i & (lrsel_i != lr_prev_q);
  assign lr_fall   = lr_edge & ~lrsel_i;
  assign bit_take  = tick_i & (idx_q < IDX_FULL);
  assign word_next = bit_take ? {shreg_q[WORD_W-2:0], sdata_i} : shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !act_i) begin
      lr_prev_q   <= 1'b0;
      synced_q    <= 1'b0;
      left_seen_q <= 1'b0;
      armed_q     <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
      shreg_q     <= '0;
      lhold_q     <= '0;
      emit_o      <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      short_o     <= 1'b0;
    end else begin
      emit_o  <= 1'b0;
      short_o <= 1'b0;
      if (tick_i) begin
        lr_prev_q <= lrsel_i;
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (lr_edge) begin
          // The bit on an edge tick is the LSB slot of the word that is ending.
          synced_q <= 1'b1;
          idx_q    <= '0;
          shreg_q  <= '0;
          if (synced_q) begin
            if (!lr_prev_q) begin
              lhold_q     <= word_next;
              left_seen_q <= 1'b1;
            end else if (left_seen_q) begin
              left_o      <= lhold_q;
              right_o     <= word_next;
              emit_o      <= 1'b1;
              left_seen_q <= 1'b0;
            end
          end
          if (lr_fall) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
            if (armed_q && period_too_short(32'(cnt_q), 32'(MIN_BCLK)))
              short_o <= 1'b1;
          end
        end else begin
          shreg_q <= word_next;
          if (bit_take) idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R5: a frame is only reported after a channel-select edge was seen
  a_r5_emit_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> synced_q);

  // R10: frame strobe lasts one clock
  a_r10_emit_single: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |=> !emit_o);

  // R4: the word index never runs past the word width
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_FULL);

endmodule

// File: rtl/sar_tw_framer.sv
module sar_tw_framer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              sdata_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_next;
  logic               frame_end;

  assign frame_next = {shreg_q[FRAME_W-2:0], sdata_i};
  assign frame_end  = tick_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !act_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      emit_o  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      emit_o <= 1'b0;
      if (tick_i) begin
        if (frame_end) begin
          left_o  <= frame_next[FRAME_W-1:WORD_W];
          right_o <= frame_next[WORD_W-1:0];
          emit_o  <= 1'b1;
          cnt_q   <= '0;
          shreg_q <= '0;
        end else begin
          shreg_q <= frame_next;
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8: after a frame is reported the bit position starts over
  a_r8_restart_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> (cnt_q == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W      = 16,
  parameter int MIN_BCLK    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_en_i,
  input  logic              path_en_i,
  input  logic [1:0]        fmt_i,
  input  logic              bclk_i,
  input  logic              lrsel_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  import sar_pkg::*;

  logic              port_en;
  logic              two_wire;
  logic              act_i2s;
  logic              act_tw;
  logic              tick;
  logic              lr_s;
  logic              sd_s;
  logic              i2s_emit;
  logic              i2s_short;
  logic [WORD_W-1:0] i2s_left;
  logic [WORD_W-1:0] i2s_right;
  logic              tw_emit;
  logic [WORD_W-1:0] tw_left;
  logic [WORD_W-1:0] tw_right;

  assign port_en  = card_en_i & path_en_i;
  assign two_wire = fmt_is_two_wire(fmt_i);
  assign act_i2s  = port_en & ~two_wire;
  assign act_tw   = port_en & two_wire;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_i  (bclk_i),
    .lrsel_i (lrsel_i),
    .sdata_i (sdata_i),
    .tick_o  (tick),
    .lrsel_o (lr_s),
    .sdata_o (sd_s)
  );

  sar_i2s_framer #(.WORD_W(WORD_W), .MIN_BCLK(MIN_BCLK)) u_i2s (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act_i2s),
    .tick_i  (tick),
    .lrsel_i (lr_s),
    .sdata_i (sd_s),
    .emit_o  (i2s_emit),
    .left_o  (i2s_left),
    .right_o (i2s_right),
    .short_o (i2s_short)
  );

  sar_tw_framer #(.WORD_W(WORD_W)) u_tw (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act_tw),
    .tick_i  (tick),
    .sdata_i (sd_s),
    .emit_o  (tw_emit),
    .left_o  (tw_left),
    .right_o (tw_right)
  );

  // Output stage: only the framer of the selected format may deliver
  always_ff @(posedge clk) begin
    if (!rst_n || !port_en) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (act_i2s && i2s_emit) begin
        left_o  <= i2s_left;
        right_o <= i2s_right;
        valid_o <= 1'b1;
      end else if (act_tw && tw_emit) begin
        left_o  <= tw_left;
        right_o <= tw_right;
        valid_o <= 1'b1;
      end
      frame_err_o <= frame_err_o | (act_i2s & i2s_short);
    end
  end

  // R2 / R7: a missing enable leaves the port quiet and the flag clear
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_en_i && path_en_i) |=> (!valid_o && !frame_err_o &&
                                   left_o == '0 && right_o == '0));

  // R6: the error flag holds while enabled
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (card_en_i && path_en_i && frame_err_o) |=> frame_err_o);

  // R9: two-wire mode never raises the flag
  a_r9_tw_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (card_en_i && path_en_i && fmt_i == FMT_TWO_WIRE && !frame_err_o) |=> !frame_err_o);

  // R10: the output strobe lasts one clock
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R10: words stay put between strobes
  a_r10_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
    (card_en_i && path_en_i && $past(card_en_i && path_en_i) && !valid_o)
      |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_en = 1'b0;
  logic        path_en = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        bclk = 1'b0;
  logic        lrsel = 1'b0;
  logic        sdata = 1'b0;
  logic [15:0] left_o;
  logic [15:0] right_o;
  logic        valid_o;
  logic        frame_err_o;

  int checks = 0;
  int fails  = 0;
  int ncap   = 0;
  int run    = 0;
  int max_run = 0;
  logic [15:0] cap_l [16];
  logic [15:0] cap_r [16];

  always #2 clk = ~clk;   // 250 MHz

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .card_en_i(card_en), .path_en_i(path_en),
    .fmt_i(fmt), .bclk_i(bclk), .lrsel_i(lrsel), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );

  // Port monitor: records every strobe and the longest strobe run
  always @(negedge clk) begin
    if (valid_o) begin
      if (ncap < 16) begin
        cap_l[ncap] = left_o;
        cap_r[ncap] = right_o;
      end
      ncap = ncap + 1;
      run = run + 1;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int f,
                                          input int ch);
    logic [15:0] w;
    w = seed ^ 16'(f * 16'h2F35) ^ (ch != 0 ? 16'hC30F : 16'h0000);
    return {w[10:0], w[15:11]} ^ 16'(ch * 16'h0101);
  endfunction

  // Slot bit j of a word: 16 real bits MSB first, then filler ones
  function automatic logic slot_bit(input logic [15:0] w, input int j);
    return (j < 16) ? w[15 - j] : 1'b1;
  endfunction

  task automatic slot(input logic ws, input logic sd);
    @(negedge clk);
    bclk = 1'b0; lrsel = ws; sdata = sd;
    repeat (5) @(negedge clk);
    bclk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_i2s(input int n, input int frames, input logic [15:0] seed);
    logic last = 1'b0;
    for (int f = 0; f < frames; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [15:0] w = word_of(seed, f, ch);
        for (int k = 0; k < n; k++)
          slot(ch[0], (k == 0) ? last : slot_bit(w, k - 1));
        last = slot_bit(w, n - 1);
      end
    end
    slot(1'b0, last);
    slot(1'b0, 1'b0);
    @(negedge clk); bclk = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic set_en(input logic c, input logic p, input logic [1:0] f);
    @(negedge clk);
    card_en = c; path_en = p; fmt = f;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frames(input int first, input int count, input logic [15:0] seed,
                              input string req);
    check(ncap == count, req, ncap, count);
    for (int i = 0; i < count && i < 16; i++) begin
      check(cap_l[i] == word_of(seed, first + i, 0), req, cap_l[i], word_of(seed, first + i, 0));
      check(cap_r[i] == word_of(seed, first + i, 1), req, cap_r[i], word_of(seed, first + i, 1));
    end
  endtask

  task automatic t_reset;
    check(left_o == 0 && right_o == 0, "R1 words", {left_o, right_o}, 0);
    check(!valid_o && !frame_err_o, "R1 flags", {valid_o, frame_err_o}, 0);
  endtask

  task automatic t_disabled;
    ncap = 0;
    set_en(1'b1, 1'b0, 2'b00);
    send_i2s(16, 3, 16'h1234);
    check(ncap == 0, "R2 card only", ncap, 0);
    check(left_o == 0 && right_o == 0, "R2 words", {left_o, right_o}, 0);
    set_en(1'b0, 1'b1, 2'b01);
    send_i2s(16, 3, 16'h4321);
    check(ncap == 0, "R2 path only", ncap, 0);
    check(!frame_err_o, "R2 err", frame_err_o, 0);
  endtask

  task automatic t_i2s_basic;
    ncap = 0; max_run = 0;
    set_en(1'b1, 1'b1, 2'b00);
    send_i2s(16, 4, 16'hA5C3);
    check_frames(1, 3, 16'hA5C3, "R3 R5 i2s 32 clocks");
    check(!frame_err_o, "R4 exact 32", frame_err_o, 0);
    check(max_run == 1, "R10 strobe width", max_run, 1);
    check(left_o == word_of(16'hA5C3, 3, 0) && right_o == word_of(16'hA5C3, 3, 1),
          "R10 hold", {left_o, right_o}, {word_of(16'hA5C3, 3, 0), word_of(16'hA5C3, 3, 1)});
    set_en(1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_i2s_long;
    ncap = 0;
    set_en(1'b1, 1'b1, 2'b11);
    send_i2s(24, 3, 16'h0F96);
    check_frames(1, 2, 16'h0F96, "R4 R3 i2s 48 clocks");
    check(!frame_err_o, "R4 long frame no error", frame_err_o, 0);
    set_en(1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_short;
    set_en(1'b1, 1'b1, 2'b00);
    send_i2s(15, 4, 16'h5555);
    check(frame_err_o, "R6 short frame", frame_err_o, 1);
    send_i2s(16, 3, 16'h7777);
    check(frame_err_o, "R6 sticky", frame_err_o, 1);
    set_en(1'b1, 1'b0, 2'b00);
    check(!frame_err_o, "R7 cleared", frame_err_o, 0);
    set_en(1'b1, 1'b1, 2'b00);
    check(!frame_err_o, "R7 stays clear", frame_err_o, 0);
    set_en(1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_two_wire;
    logic [15:0] seed = 16'h3C6A;
    ncap = 0;
    set_en(1'b1, 1'b1, 2'b01);
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 32; k++) begin
        logic [15:0] w = word_of(seed, f, (k < 16) ? 0 : 1);
        slot((k % 6) < 3, w[15 - (k % 16)]);
      end
    @(negedge clk); bclk = 1'b0;
    repeat (20) @(negedge clk);
    check_frames(0, 3, seed, "R8 R9 two-wire");
    check(!frame_err_o, "R9 select ignored", frame_err_o, 0);
    set_en(1'b0, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_i2s_basic();
    t_i2s_long();
    t_short();
    t_two_wire();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule